// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of why the system most recently left reset and shows that record as an 8-bit read-only register on a simple bus. Each reset source delivers a one-cycle pulse: power-on, the external reset pin, the watchdog timeout, an illegal opcode, an illegal fetch address, forced monitor-mode entry and a low supply voltage. The block turns those pulses into sticky flags. Start-up firmware reads the register once to learn the cause, and that read clears every flag.

A power-on pulse sets its own flag and wipes every other flag. Any other cause replaces whichever non-power-on cause was held before, so no more than one of those flags is set at a time. When several non-power-on pulses arrive in the same cycle, a fixed priority chooses one. The read path is combinational, so a read returns the value held before the clear. The clear then takes effect on the next clock edge, and a reset pulse in that same cycle takes precedence over it.

Top module: `reset_cause_reg`

## Requirements
- R1: Bit layout: bit 7 power-on, bit 6 external pin, bit 5 watchdog, bit 4 illegal opcode, bit 3 illegal address, bit 2 monitor entry, bit 1 low voltage, bit 0 always reads 0.
- R2: After `rst_n` is released, the register reads 0x80.
- R3: A power-on pulse leaves the register at exactly 0x80 on the next edge. This holds when it coincides with a cause pulse or a read.
- R4: A read at the register address with no pulse in that cycle clears all flags, so a second read returns 0x00.
- R5: A non-power-on pulse without a read sets its flag, clears the other cause flags and keeps the power-on flag unchanged.
- R6: Simultaneous non-power-on pulses set only the highest-priority one, in the order pin, watchdog, illegal opcode, illegal address, monitor entry, low voltage. At most one cause flag is ever set.
- R7: A cause pulse in the same cycle as a read leaves that cause flag set and clears the power-on flag.
- R8: `rd_data` shows the stored value during the read cycle. It is 0x00 when no read targets the register, and a read of any other address clears nothing.
- R9: A write strobe at the register address has no effect on the stored value.
- R10: The register responds only at address 0xFE01 (all 16 address bits compared by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low storage reset; loads the power-on state |
| por_evt | input | 1 | Power-on reset pulse |
| pin_evt | input | 1 | External pin reset pulse |
| wdog_evt | input | 1 | Watchdog timeout reset pulse |
| illop_evt | input | 1 | Illegal opcode reset pulse |
| illadr_evt | input | 1 | Illegal address reset pulse |
| mon_evt | input | 1 | Forced monitor-entry reset pulse |
| lowv_evt | input | 1 | Low-voltage reset pulse |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (ignored by the register) |
| rd_data | output | 8 | Read data |

## Verification
The assertions assume a few things about the inputs:
- every reset source is a pulse, sampled once per edge;
- a read strobe lasts exactly one cycle per access;
- read and write strobes may overlap reset pulses freely.

The stimulus drives every pulse and strobe for exactly one clock, changing them only at the falling edge. It sweeps every ordered pair of causes, all 63 non-empty sets of simultaneous causes, and every cause arriving alongside a read. Expected values come from bit arithmetic on the cause index.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   localparam int unsigned REG_W     = 8;
   localparam int unsigned N_CAUSE   = 6;
   localparam int unsigned POR_BIT   = 7;
   localparam int unsigned CAUSE_TOP = 6;
   localparam logic [REG_W-1:0] POR_STATE = 8'h80;

   function automatic int unsigned cause_pos(input int unsigned idx);
      return CAUSE_TOP - idx;
   endfunction
endpackage

// File: rtl/rcs_cause_arb.sv
module rcs_cause_arb #(
   parameter int unsigned N = 6
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant,
   output logic         any
);
   logic [N:0] blocked;

   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]     = req[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | req[i];
   end

   assign any = blocked[N];

   initial begin
      assert (N >= 1) else $error("rcs_cause_arb: N must be at least 1");
   end
endmodule

// File: rtl/rcs_bus_decode.sv
module rcs_bus_decode #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned REG_ADDR  = 32'h0000_FE01,
   parameter int unsigned ADDR_MASK = 32'h0000_FFFF
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic              rd_hit,
   output logic              wr_hit
);
   localparam logic [ADDR_W-1:0] MASK_V = ADDR_W'(ADDR_MASK);
   localparam logic [ADDR_W-1:0] MATCH  = ADDR_W'(REG_ADDR) & MASK_V;

   logic sel;

   assign sel    = ((bus_addr & MASK_V) == MATCH);
   assign rd_hit = sel & bus_rd;
   assign wr_hit = sel & bus_wr;

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 31) else $error("rcs_bus_decode: ADDR_W out of range");
      assert (REG_ADDR < (32'd1 << ADDR_W)) else $error("rcs_bus_decode: REG_ADDR wider than bus");
   end
endmodule

// File: rtl/rcs_flag_store.sv
module rcs_flag_store #(
   parameter int unsigned N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         por_evt,
   input  logic [N-1:0] grant,
   input  logic         any_cause,
   input  logic         rd_hit,
   output logic         por_flag,
   output logic [N-1:0] cause_flags
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         por_flag    <= 1'b1;
         cause_flags <= '0;
      end else if (por_evt) begin
         por_flag    <= 1'b1;
         cause_flags <= '0;
      end else begin
         if (rd_hit)
            por_flag <= 1'b0;
         if (any_cause)
            cause_flags <= grant;
         else if (rd_hit)
            cause_flags <= '0;
      end
   end

   a_r6_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cause_flags));

   a_r3_por_state: assert property (@(posedge clk) disable iff (!rst_n)
      por_evt |=> (por_flag && cause_flags == '0));

   a_r5_replace: assert property (@(posedge clk) disable iff (!rst_n)
      (!por_evt && any_cause) |=> (cause_flags == $past(grant)));

   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && !por_evt && !any_cause) |=> (!por_flag && cause_flags == '0));

   a_r5_por_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!por_evt && !rd_hit) |=> (por_flag == $past(por_flag)));
endmodule

// File: rtl/reset_cause_reg.sv
module reset_cause_reg #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned REG_ADDR   = 32'h0000_FE01,
   parameter int unsigned ADDR_MASK  = 32'h0000_FFFF,
   parameter bit          IDLE_ZERO  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_evt,
   input  logic              pin_evt,
   input  logic              wdog_evt,
   input  logic              illop_evt,
   input  logic              illadr_evt,
   input  logic              mon_evt,
   input  logic              lowv_evt,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic [7:0]        rd_data
);
   import rcs_pkg::*;

   localparam int unsigned N = N_CAUSE;

   logic [N-1:0]     req;
   logic [N-1:0]     grant;
   logic             any_cause;
   logic             rd_hit;
   logic             wr_hit;
   logic             por_flag;
   logic [N-1:0]     cause_flags;
   logic [REG_W-1:0] status;

   // index 0 has the highest priority
   assign req = {lowv_evt, mon_evt, illadr_evt, illop_evt, wdog_evt, pin_evt};

   rcs_cause_arb #(.N(N)) u_arb (
      .req   (req),
      .grant (grant),
      .any   (any_cause)
   );

   rcs_bus_decode #(
      .ADDR_W    (ADDR_W),
      .REG_ADDR  (REG_ADDR),
      .ADDR_MASK (ADDR_MASK)
   ) u_dec (
      .bus_addr (bus_addr),
      .bus_rd   (bus_rd),
      .bus_wr   (bus_wr),
      .rd_hit   (rd_hit),
      .wr_hit   (wr_hit)
   );

   rcs_flag_store #(.N(N)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .por_evt     (por_evt),
      .grant       (grant),
      .any_cause   (any_cause),
      .rd_hit      (rd_hit),
      .por_flag    (por_flag),
      .cause_flags (cause_flags)
   );

   assign status[POR_BIT] = por_flag;
   assign status[0]       = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_map
      assign status[cause_pos(i)] = cause_flags[i];
   end

   if (IDLE_ZERO) begin : g_rd_gated
      assign rd_data = rd_hit ? status : '0;
   end else begin : g_rd_open
      assign rd_data = status;
   end

   initial begin
      assert (REG_W == 8) else $error("reset_cause_reg: register must be 8 bits");
      assert (N + 2 == REG_W) else $error("reset_cause_reg: cause count does not fit layout");
   end

   a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !rd_hit && !por_evt && !any_cause) |=> $stable(status));

   a_r7_event_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && any_cause && !por_evt) |=> (status[POR_BIT] == 1'b0 && status[6:1] != '0));

   a_r1_bit0_low: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |-> (rd_data[0] == 1'b0));
endmodule

// File: tb/test_reset_cause_reg.sv
`timescale 1ns/1ps
module test_reset_cause_reg;
   localparam logic [15:0] REG = 16'hFE01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        por = 1'b0;
   logic [5:0]  ev = '0;
   logic [15:0] addr = '0;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [7:0]  rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   reset_cause_reg i_reset_cause_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .por_evt    (por),
      .pin_evt    (ev[0]),
      .wdog_evt   (ev[1]),
      .illop_evt  (ev[2]),
      .illadr_evt (ev[3]),
      .mon_evt    (ev[4]),
      .lowv_evt   (ev[5]),
      .bus_addr   (addr),
      .bus_rd     (rd),
      .bus_wr     (wr),
      .rd_data    (rd_data)
   );

   function automatic logic [7:0] bitof(input int idx);
      return 8'h01 << (6 - idx);
   endfunction

   function automatic int lowest(input logic [5:0] m);
      for (int k = 0; k < 6; k++) if (m[k]) return k;
      return -1;
   endfunction

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic p, input logic [5:0] c);
      @(negedge clk);
      por = p; ev = c;
      @(posedge clk); #1;
      por = 1'b0; ev = '0;
   endtask

   task automatic read_at(input logic [15:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #2 check(rd_data, exp, tag);
      @(posedge clk); #1;
      rd = 1'b0;
   endtask

   task automatic read_with(input logic p, input logic [5:0] c, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr = REG; rd = 1'b1; por = p; ev = c;
      #2 check(rd_data, exp, tag);
      @(posedge clk); #1;
      rd = 1'b0; por = 1'b0; ev = '0;
   endtask

   task automatic write_at(input logic [15:0] a);
      @(negedge clk);
      addr = a; wr = 1'b1;
      @(posedge clk); #1;
      wr = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R2 / R1 power-on value, R4 second read empty
      read_at(REG, 8'h80, "R2 reset value");
      read_at(REG, 8'h00, "R4 second read");

      // R8 / R10 other addresses neither respond nor clear
      pulse(1'b0, 6'b000001);
      read_at(16'hFE00, 8'h00, "R10 addr FE00");
      read_at(16'hFE02, 8'h00, "R10 addr FE02");
      read_at(16'h7E01, 8'h00, "R10 addr 7E01");
      read_at(16'hFF01, 8'h00, "R10 addr FF01");
      @(negedge clk); addr = REG;
      #2 check(rd_data, 8'h00, "R8 idle output");
      read_at(REG, 8'h40, "R8 value kept");
      read_at(REG, 8'h00, "R4 cleared");

      // R9 writes ignored
      pulse(1'b0, 6'b000010);
      write_at(REG);
      read_at(REG, 8'h20, "R9 after write");
      write_at(REG);
      read_at(REG, 8'h00, "R9 write after clear");

      // R5 / R1 every ordered pair of causes
      for (int a = 0; a < 6; a++) begin
         for (int b = 0; b < 6; b++) begin
            pulse(1'b0, 6'(1 << a));
            pulse(1'b0, 6'(1 << b));
            read_at(REG, bitof(b), "R5 pair replace");
         end
      end

      // R5 power-on flag kept, R3 power-on wipes cause
      for (int c = 0; c < 6; c++) begin
         pulse(1'b1, '0);
         pulse(1'b0, 6'(1 << c));
         read_at(REG, 8'h80 | bitof(c), "R5 por kept");
         pulse(1'b0, 6'(1 << c));
         pulse(1'b1, '0);
         read_at(REG, 8'h80, "R3 por wipes");
         pulse(1'b1, 6'(1 << c));
         read_at(REG, 8'h80, "R3 por with cause");
      end

      // R6 all non-empty sets of simultaneous causes
      for (int m = 1; m < 64; m++) begin
         pulse(1'b0, 6'(m));
         read_at(REG, bitof(lowest(6'(m))), "R6 priority");
      end

      // R7 cause with read in same cycle
      for (int c = 0; c < 6; c++) begin
         pulse(1'b1, '0);
         read_with(1'b0, 6'(1 << c), 8'h80, "R8 value before clear");
         read_at(REG, bitof(c), "R7 event beats read");
      end

      // R3 power-on with read in same cycle
      pulse(1'b0, 6'b100000);
      read_with(1'b1, '0, 8'h02, "R8 old value");
      read_at(REG, 8'h80, "R3 por beats read");
      read_at(REG, 8'h00, "R4 final clear");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule